// File: doc/BRIEF.md
# Per-Pipe Interrupt Status Aggregator

This block gathers event flags from every pipe of a multi-pipe USB controller for three event classes: buffer empty, buffer not ready and buffer ready. Each class keeps one status bit and one enable bit per pipe. A pipe event pulse sets that pipe's status bit. Software clears a status bit by writing 0 to it; writing 1 leaves it as it is. For each class a read-only summary bit is 1 while any pipe has both its status bit and its enable bit set.

A separate stage flag records control-transfer stage transitions. When a transition pulse arrives, the flag sets and the accompanying stage code is stored. Software reads the code and clears the flag. The interrupt request output combines the three summary bits and the stage flag. Each source passes through its own enable bit in a control register.

Software reaches all state through a single-cycle register port. Writes take effect on the next clock edge. Reads are combinational from the current register state.

Top module: `pipe_irq_aggregator`

## Requirements
- R1: An event pulse on a pipe's input sets that pipe's status bit in its class, visible one cycle after the pulse.
- R2: A software write to a status register clears each bit written as 0 and leaves each bit written as 1 unchanged. An event on a pipe in the same cycle as a clear of that pipe wins, and the bit stays 1.
- R3: A class summary bit (summary register bit 0 empty, bit 1 not-ready, bit 2 ready) reads 1 exactly when some pipe has both its status and its enable bit set. A pipe whose enable bit is 0 never contributes.
- R4: A summary bit stays 1 while any enabled status bit in its class is still set. It falls only once software has cleared all of them.
- R5: Writes to summary register bits 2:0 have no effect on the summary bits.
- R6: A stage-transition pulse sets the stage flag (summary register bit 3) and stores the stage code input in summary register bits 6:4, both visible one cycle later.
- R7: Writing 0 to summary bit 3 clears the stage flag, and writing 1 there has no effect. A transition in the same cycle as a clear keeps the flag set. The stored stage code cannot be written by software.
- R8: The irq output is 1 exactly when an active source is enabled. The control register (address 0) enables the sources: bit 0 empty, bit 1 not-ready, bit 2 ready, bit 3 stage flag.
- R9: After reset, every status, enable and control register, the stage flag and the stage code read 0, and irq is 0.
- R10: Enable registers and the control register read back the value written. Register addresses are 0 control, 1 summary, 2/3 empty status/enable, 4/5 not-ready status/enable and 6/7 ready status/enable. Bits above the pipe count read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| empty_evt | input | NUM_PIPES | Buffer-empty event pulses per pipe |
| notrdy_evt | input | NUM_PIPES | Buffer-not-ready event pulses per pipe |
| ready_evt | input | NUM_PIPES | Buffer-ready event pulses per pipe |
| stage_evt | input | 1 | Control-transfer stage transition pulse |
| stage_code_in | input | 3 | Stage code accompanying stage_evt |
| irq | output | 1 | Interrupt request |

## Verification
Every state bit of this block reaches the ports in the cycle after it changes: status and enable registers read back directly, and the summary and irq outputs follow combinationally. A lost event, a wrong clear mask or a mis-gated enable therefore shows as a wrong status read or a wrong summary or irq value one cycle after the stimulus. The bench sweeps every status and enable combination of a four-pipe instance in all three classes. It also drives the collisions between software clears and hardware events.

// File: rtl/pipe_irq_pkg.sv
package pipe_irq_pkg;

    localparam int NUM_CLASSES = 3;
    localparam int ADDR_W      = 4;
    localparam int REG_W       = 16;
    localparam int CODE_W      = 3;

    typedef enum logic [1:0] {
        CLS_EMPTY  = 2'd0,
        CLS_NOTRDY = 2'd1,
        CLS_READY  = 2'd2
    } evt_class_e;

    localparam logic [ADDR_W-1:0] ADDR_CTRL    = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_SUMMARY = 4'h1;

    localparam int SUM_STAGE_BIT = 3;
    localparam int SUM_CODE_LSB  = 4;

    function automatic logic [ADDR_W-1:0] sts_addr(input int cls);
        return ADDR_W'(2 + 2 * cls);
    endfunction

    function automatic logic [ADDR_W-1:0] en_addr(input int cls);
        return ADDR_W'(3 + 2 * cls);
    endfunction

    typedef struct packed {
        logic                stage_en;
        logic [NUM_CLASSES-1:0] class_en;
    } irq_ctrl_t;

endpackage

// File: rtl/pipe_irq_class.sv
module pipe_irq_class #(
    parameter int NUM_PIPES = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sts_wr,
    input  logic                 en_wr,
    input  logic [NUM_PIPES-1:0] wdata,
    input  logic [NUM_PIPES-1:0] evt,
    output logic [NUM_PIPES-1:0] sts_q,
    output logic [NUM_PIPES-1:0] en_q,
    output logic                 summary
);

    logic [NUM_PIPES-1:0] sts_d;
    logic [NUM_PIPES-1:0] keep_mask;

    always_comb begin
        keep_mask = sts_wr ? wdata : '1;
        sts_d     = (sts_q & keep_mask) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= sts_d;
            if (en_wr) en_q <= wdata;
        end
    end

    assign summary = |(sts_q & en_q);

    // R1: every pulsed pipe shows set next cycle
    assert_evt_sets_R1: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((sts_q & $past(evt)) == $past(evt)));

    // R2: status bits never rise without an event
    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (rst)
        (evt == '0) |=> ((sts_q & ~$past(sts_q)) == '0));

    // R4: summary holds while neither status nor enable is written
    assert_summary_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (summary && !sts_wr && !en_wr) |=> summary);

endmodule

// File: rtl/pipe_irq_stage.sv
module pipe_irq_stage
    import pipe_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sum_wr,
    input  logic              flag_wbit,
    input  logic              evt,
    input  logic [CODE_W-1:0] code_in,
    output logic              flag_q,
    output logic [CODE_W-1:0] code_q
);

    logic clear_req;
    assign clear_req = sum_wr && !flag_wbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            code_q <= '0;
        end else begin
            if (evt) begin
                flag_q <= 1'b1;
                code_q <= code_in;
            end else if (clear_req) begin
                flag_q <= 1'b0;
            end
        end
    end

    // R6: a transition sets the flag and captures the code
    assert_stage_capture_R6: assert property (@(posedge clk) disable iff (rst)
        evt |=> (flag_q && code_q == $past(code_in)));

    // R7: the flag only falls after a software clear
    assert_flag_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(clear_req));

    // R7: the code only changes on a transition
    assert_code_ro_R7: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(code_q));

endmodule

// File: rtl/pipe_irq_aggregator.sv
module pipe_irq_aggregator
    import pipe_irq_pkg::*;
#(
    parameter int NUM_PIPES = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [3:0]           reg_addr,
    input  logic [15:0]          reg_wdata,
    output logic [15:0]          reg_rdata,
    input  logic [NUM_PIPES-1:0] empty_evt,
    input  logic [NUM_PIPES-1:0] notrdy_evt,
    input  logic [NUM_PIPES-1:0] ready_evt,
    input  logic                 stage_evt,
    input  logic [2:0]           stage_code_in,
    output logic                 irq
);

    localparam int CTRL_W = NUM_CLASSES + 1;

    logic [NUM_PIPES-1:0]   evt_vec   [NUM_CLASSES];
    logic [NUM_PIPES-1:0]   sts_vec   [NUM_CLASSES];
    logic [NUM_PIPES-1:0]   en_vec    [NUM_CLASSES];
    logic [NUM_CLASSES-1:0] summary_vec;
    logic                   stage_flag;
    logic [CODE_W-1:0]      stage_code;
    irq_ctrl_t              ctrl_q;

    assign evt_vec[CLS_EMPTY]  = empty_evt;
    assign evt_vec[CLS_NOTRDY] = notrdy_evt;
    assign evt_vec[CLS_READY]  = ready_evt;

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= irq_ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
        pipe_irq_class #(.NUM_PIPES(NUM_PIPES)) u_class (
            .clk     (clk),
            .rst     (rst),
            .sts_wr  (reg_wr && reg_addr == sts_addr(c)),
            .en_wr   (reg_wr && reg_addr == en_addr(c)),
            .wdata   (reg_wdata[NUM_PIPES-1:0]),
            .evt     (evt_vec[c]),
            .sts_q   (sts_vec[c]),
            .en_q    (en_vec[c]),
            .summary (summary_vec[c])
        );
    end

    pipe_irq_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .sum_wr    (reg_wr && reg_addr == ADDR_SUMMARY),
        .flag_wbit (reg_wdata[SUM_STAGE_BIT]),
        .evt       (stage_evt),
        .code_in   (stage_code_in),
        .flag_q    (stage_flag),
        .code_q    (stage_code)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL:    reg_rdata = 16'(ctrl_q);
            ADDR_SUMMARY: reg_rdata = 16'({stage_code, stage_flag, summary_vec});
            default: begin
                for (int c = 0; c < NUM_CLASSES; c++) begin
                    if (reg_addr == sts_addr(c)) reg_rdata = 16'(sts_vec[c]);
                    if (reg_addr == en_addr(c))  reg_rdata = 16'(en_vec[c]);
                end
            end
        endcase
    end

    assign irq = |(summary_vec & ctrl_q.class_en) | (stage_flag & ctrl_q.stage_en);

    // R8: with every source disabled, no interrupt can be raised
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q == '0) |-> !irq);

endmodule

// File: tb/pipe_irq_aggregator_bench.sv
module pipe_irq_aggregator_bench;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [NP-1:0] evt [3];
    logic          stage_evt = 1'b0;
    logic [2:0]    stage_code_in = '0;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pipe_irq_aggregator #(.NUM_PIPES(NP)) u_pipe_irq_aggregator (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .empty_evt(evt[0]), .notrdy_evt(evt[1]), .ready_evt(evt[2]),
        .stage_evt(stage_evt), .stage_code_in(stage_code_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input int c, input logic [NP-1:0] v);
        @(negedge clk);
        evt[c] = v;
        @(negedge clk);
        evt[c] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        evt[0] = '0; evt[1] = '0; evt[2] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), d);
            chk("R9 reset register", d, 16'h0);
        end
        chk("R9 reset irq", 16'(irq), 16'h0);

        // R1 R2 R3 R8 R10: exhaustive sweep per class
        for (int c = 0; c < 3; c++) begin
            wr(4'h0, 16'(1 << c));
            rd(4'h0, d);
            chk("R10 ctrl readback", d, 16'(1 << c));
            for (int e = 0; e < 16; e++) begin
                wr(4'(3 + 2 * c), 16'(e) | 16'hFFF0);
                rd(4'(3 + 2 * c), d);
                chk("R10 enable readback", d, 16'(e));
                for (int s = 0; s < 16; s++) begin
                    wr(4'(2 + 2 * c), 16'h0);
                    pulse(c, 4'(s));
                    rd(4'(2 + 2 * c), d);
                    chk("R1 status set by events", d, 16'(s));
                    rd(4'h1, d);
                    chk("R3 summary", d, 16'(((s & e) != 0) << c));
                    chk("R8 irq", 16'(irq), 16'((s & e) != 0));
                    wr(4'(2 + 2 * c), 16'hFFFF);
                    rd(4'(2 + 2 * c), d);
                    chk("R2 write one keeps", d, 16'(s));
                end
            end
            wr(4'(2 + 2 * c), 16'h0);
            wr(4'(3 + 2 * c), 16'h0);
        end

        // R4: progressive clear with all enabled
        wr(4'h0, 16'h1);
        wr(4'h3, 16'hF);
        pulse(0, 4'hF);
        for (int k = 0; k < 4; k++) begin
            logic [3:0] remain;
            remain = 4'(4'hF << (k + 1));
            wr(4'h2, 16'(remain));
            rd(4'h1, d);
            chk("R4 summary during partial clear", 16'(d[0]), 16'(remain != 0));
            chk("R4 irq during partial clear", 16'(irq), 16'(remain != 0));
        end
        // R4: only a disabled bit left set
        wr(4'h3, 16'h5);
        pulse(0, 4'hA);
        rd(4'h1, d);
        chk("R4 disabled bits only", 16'(d[0]), 16'h0);

        // R5: summary ignores writes
        pulse(0, 4'h1);
        wr(4'h1, 16'h0000);
        rd(4'h1, d);
        chk("R5 summary ignores write 0", 16'(d[2:0]), 16'h1);
        wr(4'h1, 16'h0007);
        pulse(1, 4'h0);
        rd(4'h1, d);
        chk("R5 summary ignores write 1", 16'(d[2:0]), 16'h1);

        // R2: event beats simultaneous clear
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h2; reg_wdata = 16'h0; evt[0] = 4'h4;
        @(negedge clk);
        reg_wr = 1'b0; evt[0] = '0;
        rd(4'h2, d);
        chk("R2 event wins over clear", d, 16'h4);
        wr(4'h2, 16'h0);
        wr(4'h3, 16'h0);

        // R6: stage capture
        wr(4'h0, 16'h8);
        chk("R8 irq idle stage", 16'(irq), 16'h0);
        @(negedge clk);
        stage_evt = 1'b1; stage_code_in = 3'd5;
        @(negedge clk);
        stage_evt = 1'b0; stage_code_in = 3'd0;
        rd(4'h1, d);
        chk("R6 stage flag", 16'(d[3]), 16'h1);
        chk("R6 stage code", 16'(d[6:4]), 16'h5);
        chk("R8 irq from stage", 16'(irq), 16'h1);

        // R7: write 1 no effect, code read-only, write 0 clears
        wr(4'h1, 16'h0008);
        rd(4'h1, d);
        chk("R7 write one keeps flag", 16'(d[3]), 16'h1);
        wr(4'h1, 16'h0070);
        rd(4'h1, d);
        chk("R7 flag cleared", 16'(d[3]), 16'h0);
        chk("R7 code read-only", 16'(d[6:4]), 16'h5);
        chk("R8 irq after stage clear", 16'(irq), 16'h0);

        // R7: transition during clear
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h1; reg_wdata = 16'h0;
        stage_evt = 1'b1; stage_code_in = 3'd2;
        @(negedge clk);
        reg_wr = 1'b0; stage_evt = 1'b0;
        rd(4'h1, d);
        chk("R7 transition wins over clear", 16'(d[6:3]), 16'h5);

        // R8: stage flag gated off
        wr(4'h0, 16'h7);
        chk("R8 stage gated", 16'(irq), 16'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule